// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block sits between a simple host port and a 4096 x 1 dynamic memory whose address pins carry the row and then the column. A host read or write becomes one timed strobe sequence. The row half of the address is driven first and captured when the row strobe falls. The column half follows and is captured when the column strobe falls. The write-enable and data pins are driven around these strobes.

An internal timer marks when a refresh is due. The controller then runs a row-strobe-only cycle on the row held by its own pointer, and the pointer advances after each refresh. A refresh that falls due during a host access waits until that access ends. A due refresh is served before any new host request. Every strobe phase lasts a parameterised number of clocks.

The host raises `req` for one clock while `ready` is high, with `wr`, `addr` and `wdata` valid. It may send the next request once `ready` returns. For a read, `rdata` holds the fetched bit from then on.

Top module: `dramc_top`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `ras_n`, `cas_n` and `we_n` are 1, `ready` is 1 and `rdata` is 0.
- R2: For a host access, `ma` equals `addr[11:6]` (row) when `ras_n` falls and `addr[5:0]` (column) when `cas_n` falls. `cas_n` falls only while `ras_n` is 0.
- R3: A write drives `we_n` to 0 and `mdin` to the write bit before `cas_n` falls. `ras_n` then rises while `cas_n` is still 0, and `cas_n` rises only after `ras_n` is high.
- R4: A read keeps `we_n` at 1. When `ready` returns, `rdata` equals the bit last written to that address (0 if the address was never written).
- R5: `ras_n` and `cas_n` each hold every level for at least `T_PH` clock cycles between changes.
- R6: A refresh lowers `ras_n` with `ma` equal to the refresh row pointer, keeps `cas_n` and `we_n` at 1, and visits rows 0, 1, ..., 63, then 0 again.
- R7: With the host idle, successive refresh cycles are exactly `REF_CYCLES` clocks apart.
- R8: A refresh never starts inside a host access. Under back-to-back host traffic, refreshes still occur once per `REF_CYCLES`, within one interval.
- R9: `req` is taken only while `ready` is 1. A request raised while an access is in progress leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, taken when ready is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Host word address, row in [11:6], column in [5:0] |
| wdata | input | 1 | Write bit |
| rdata | output | 1 | Last read bit |
| ready | output | 1 | Idle with no refresh pending |
| ma | output | 6 | Multiplexed memory address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mdin | output | 1 | Data driven to the memory |
| mdout | input | 1 | Data from the memory, valid while cas_n is 0 |

## Verification
An accepted request runs six phases of `T_PH` cycles, so `ready` comes back 6*T_PH clocks after the accepting edge, and `rdata` is captured at the end of the column phase. The bench therefore reads `rdata` only after it has seen `ready` high on a falling clock edge. Address, write-enable and data are checked by a behavioural memory at the strobe edges themselves, since those are the instants the memory latches them. The refresh spacing is measured between successive refresh row-strobe rises in simulation time. It is compared only when both refreshes happen with the host idle, because only then is the latency from the timer to the strobe constant.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_AROW,   // row address setup, strobes high
    S_ARAS,   // row strobe low
    S_ACOL,   // column address setup under row strobe
    S_ACAS,   // column strobe low, bit transferred
    S_ARUP,   // row strobe rises, write-back of the row
    S_AEND,   // column strobe rises, precharge
    S_RROW,   // refresh row setup
    S_RRAS,   // refresh row strobe low
    S_REND    // refresh precharge
  } dram_st_e;

  function automatic logic [15:0] wrap_inc(input logic [15:0] v, input logic [15:0] lim);
    return (v == lim - 16'd1) ? 16'd0 : v + 16'd1;
  endfunction

endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer
  import dramc_pkg::*;
#(
  parameter int REF_CYCLES = 7812,
  parameter int ROW_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_done,
  output logic             rf_pend,
  output logic [ROW_W-1:0] rf_row
);
  localparam int CNT_W = $clog2(REF_CYCLES + 1);
  localparam int ROWS  = 1 << ROW_W;

  logic [CNT_W-1:0] cnt;
  logic             rf_tick;
  logic [15:0]      row_nx;

  assign rf_tick = (cnt == CNT_W'(REF_CYCLES - 1));
  assign row_nx  = wrap_inc(16'(rf_row), 16'(ROWS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rf_pend <= 1'b0;
      rf_row  <= '0;
    end else begin
      cnt <= rf_tick ? '0 : cnt + 1'b1;
      if (rf_tick)      rf_pend <= 1'b1;
      else if (rf_done) rf_pend <= 1'b0;
      if (rf_done) rf_row <= row_nx[ROW_W-1:0];
    end
  end

  // R6
  row_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_done |=> rf_row == ROW_W'($past(rf_row) + 1'b1));

  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_done |=> $stable(rf_row));

  // R7
  tick_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_tick |=> rf_pend);

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 6,
  parameter int T_PH  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   wdata,
  input  logic                   mdout,
  input  logic                   rf_pend,
  input  logic [ROW_W-1:0]       rf_row,
  output logic                   ready,
  output logic                   rdata,
  output logic [ROW_W-1:0]       ma,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   mdin,
  output logic                   rf_done
);
  localparam int PH_W  = $clog2(T_PH + 1);
  localparam int ADR_W = ROW_W + COL_W;

  dram_st_e         st, st_nx;
  logic [PH_W-1:0]  ph;
  logic [ADR_W-1:0] a_q;
  logic             wr_q, wd_q;

  logic ph_last, acc_start, ref_start, col_phase, in_ref, ras_low, cas_low;

  assign ph_last   = (ph == PH_W'(T_PH - 1));
  assign ready     = (st == S_IDLE) && !rf_pend;
  assign ref_start = (st == S_IDLE) && rf_pend;
  assign acc_start = ready && req;
  assign col_phase = (st == S_ACOL) || (st == S_ACAS) || (st == S_ARUP);
  assign in_ref    = (st == S_RROW) || (st == S_RRAS) || (st == S_REND);
  assign ras_low   = (st == S_ARAS) || (st == S_ACOL) || (st == S_ACAS) || (st == S_RRAS);
  assign cas_low   = (st == S_ACAS) || (st == S_ARUP);
  assign rf_done   = (st == S_REND) && ph_last;

  always_comb begin
    st_nx = st;
    if (st == S_IDLE) begin
      if (ref_start)      st_nx = S_RROW;
      else if (acc_start) st_nx = S_AROW;
    end else if (ph_last) begin
      case (st)
        S_AROW:  st_nx = S_ARAS;
        S_ARAS:  st_nx = S_ACOL;
        S_ACOL:  st_nx = S_ACAS;
        S_ACAS:  st_nx = S_ARUP;
        S_ARUP:  st_nx = S_AEND;
        S_RROW:  st_nx = S_RRAS;
        S_RRAS:  st_nx = S_REND;
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= '0;
      a_q   <= '0;
      wr_q  <= 1'b0;
      wd_q  <= 1'b0;
      rdata <= 1'b0;
    end else begin
      st <= st_nx;
      ph <= (st_nx != st) ? '0 : ph + 1'b1;
      if (acc_start) begin
        a_q  <= addr;
        wr_q <= wr;
        wd_q <= wdata;
      end
      if ((st == S_ACAS) && ph_last && !wr_q) rdata <= mdout;
    end
  end

  assign ras_n = !ras_low;
  assign cas_n = !cas_low;
  assign we_n  = !(wr_q && col_phase);
  assign mdin  = wd_q;
  assign ma    = in_ref    ? rf_row :
                 col_phase ? a_q[COL_W-1:0] : a_q[ADR_W-1:COL_W];

  // strobe run-length tracker for the phase-width check
  logic [1:0]      strb_q;
  logic [PH_W-1:0] hold;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= 2'b11;
      hold   <= '0;
    end else begin
      strb_q <= {ras_n, cas_n};
      if ({ras_n, cas_n} != strb_q) hold <= PH_W'(1);
      else if (hold != PH_W'(T_PH)) hold <= hold + 1'b1;
    end
  end

  // R5
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ras_n, cas_n} != strb_q) |-> hold >= PH_W'(T_PH));

  // R2
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !ras_n);

  // R3
  cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> ras_n);

  // R8
  ref_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |=> cas_n && we_n);

endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
  parameter int ROW_W      = 6,
  parameter int COL_W      = 6,
  parameter int T_PH       = 2,
  parameter int REF_CYCLES = 7812
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   wdata,
  output logic                   rdata,
  output logic                   ready,
  output logic [ROW_W-1:0]       ma,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   mdin,
  input  logic                   mdout
);
  logic             rf_pend, rf_done;
  logic [ROW_W-1:0] rf_row;

  dramc_ref_timer #(.REF_CYCLES(REF_CYCLES), .ROW_W(ROW_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rf_done(rf_done),
    .rf_pend(rf_pend), .rf_row(rf_row)
  );

  dramc_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_PH(T_PH)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .mdout(mdout), .rf_pend(rf_pend), .rf_row(rf_row),
    .ready(ready), .rdata(rdata), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .mdin(mdin), .rf_done(rf_done)
  );

endmodule

// File: tb/tb_dramc_top.sv
`timescale 1ns/1ps
module tb_dramc_top;
  localparam int T_PH = 2;
  localparam int REF  = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, wdata = 1'b0;
  logic [11:0] addr = '0;
  logic rdata, ready, ras_n, cas_n, we_n, mdin, mdout;
  logic [5:0] ma;

  always #4 clk = ~clk;

  dramc_top #(.T_PH(T_PH), .REF_CYCLES(REF)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .mdin(mdin), .mdout(mdout)
  );

  int nvec = 0, nfail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int row_of(input int a); return a / 64; endfunction
  function automatic int col_of(input int a); return a % 64; endfunction

  // behavioural memory and bench reference
  bit mem [4096];
  bit ref_mem [4096];
  bit [5:0] m_row = '0, m_col = '0;
  bit live = 1'b0, busy = 1'b0, cas_seen = 1'b0, idle_mode = 1'b0, last_idle = 1'b0;
  bit cur_wr = 1'b0, cur_wd = 1'b0, wrap_seen = 1'b0;
  int cur_addr = 0, exp_ptr = 0, ref_cnt = 0;
  longint last_ref_t = 0;

  assign mdout = cas_n ? 1'bz : mem[{m_row, m_col}];

  always @(negedge ras_n) if (live) begin
    m_row = ma; cas_seen = 1'b0;
    if (busy) begin
      check(int'(ma) == row_of(cur_addr), "R2 row address", int'(ma), row_of(cur_addr));
    end else begin
      check(int'(ma) == exp_ptr, "R6 refresh row", int'(ma), exp_ptr);
      check(we_n == 1'b1 && cas_n == 1'b1, "R6 refresh we_n/cas_n", int'({we_n, cas_n}), 3);
    end
  end

  always @(negedge cas_n) if (live) begin
    cas_seen = 1'b1; m_col = ma;
    check(busy, "R8 column strobe outside host access", int'(busy), 1);
    check(ras_n == 1'b0, "R2 cas under ras", int'(ras_n), 0);
    check(int'(ma) == col_of(cur_addr), "R2 column address", int'(ma), col_of(cur_addr));
    check(we_n == !cur_wr, cur_wr ? "R3 we_n low on write" : "R4 we_n high on read",
          int'(we_n), int'(!cur_wr));
    if (!we_n) begin
      check(mdin == cur_wd, "R3 write data", int'(mdin), int'(cur_wd));
      mem[{m_row, m_col}] = mdin;
    end
  end

  always @(posedge ras_n) if (live) begin
    if (cas_seen) begin
      check(cas_n == 1'b0, "R3 ras rises before cas", int'(cas_n), 0);
    end else begin
      if (exp_ptr == 63) wrap_seen = 1'b1;
      exp_ptr = (exp_ptr + 1) % 64;
      ref_cnt++;
      if (idle_mode && last_idle)
        check(($time - last_ref_t) == REF * 8, "R7 refresh interval",
              int'(($time - last_ref_t) / 8), REF);
      last_ref_t = $time; last_idle = idle_mode;
    end
  end

  always @(posedge cas_n) if (live) begin
    check(ras_n == 1'b1, "R3 cas rises after ras", int'(ras_n), 1);
    busy = 1'b0;
  end

  // strobe phase widths
  logic ras_l = 1'b1, cas_l = 1'b1;
  int ras_run = 0, cas_run = 0;
  always @(negedge clk) if (live) begin
    if (ras_n != ras_l) begin
      check(ras_run >= T_PH, "R5 ras phase width", ras_run, T_PH);
      ras_run = 1;
    end else ras_run++;
    if (cas_n != cas_l) begin
      check(cas_run >= T_PH, "R5 cas phase width", cas_run, T_PH);
      cas_run = 1;
    end else cas_run++;
    ras_l = ras_n; cas_l = cas_n;
  end

  task automatic do_op(input bit w, input int a, input bit d, input bit poke);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = 12'(a); wdata = d;
    cur_wr = w; cur_addr = a; cur_wd = d; busy = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      // R9: request raised mid-access must be ignored
      repeat (3) @(negedge clk);
      check(!ready, "R9 ready low during access", int'(ready), 0);
      req = 1'b1; wr = 1'b1; addr = 12'((a + 1) % 4096); wdata = !ref_mem[(a + 1) % 4096];
      @(negedge clk);
      req = 1'b0;
    end
    while (!ready) @(negedge clk);
    if (w) ref_mem[a] = d;
    else check(rdata == ref_mem[a], "R4 read data", int'(rdata), int'(ref_mem[a]));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0, pool;
    longint t0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n, "R1 strobes in reset", int'({ras_n, cas_n, we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    check(rdata == 1'b0, "R1 rdata after reset", int'(rdata), 0);
    check(ras_n && cas_n && we_n, "R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);

    // directed corners
    do_op(1'b0, 0, 1'b0, 1'b0);
    do_op(1'b1, 0, 1'b1, 1'b0);
    do_op(1'b1, 4095, 1'b1, 1'b0);
    do_op(1'b0, 0, 1'b0, 1'b0);
    do_op(1'b0, 4095, 1'b0, 1'b0);
    do_op(1'b1, 4095, 1'b0, 1'b0);
    do_op(1'b0, 4095, 1'b0, 1'b0);
    do_op(1'b1, 100, 1'b1, 1'b1);
    do_op(1'b0, 101, 1'b0, 1'b0);
    do_op(1'b0, 100, 1'b0, 1'b0);

    // back-to-back random traffic
    r0 = ref_cnt; t0 = $time;
    for (int i = 0; i < 500; i++) begin
      pool = ($urandom % 4 == 0) ? int'($urandom % 4096) : int'(($urandom % 16) * 257 % 4096);
      do_op(1'($urandom % 2), pool, 1'($urandom % 2), 1'($urandom % 16 == 0));
    end
    check((ref_cnt - r0) >= int'(($time - t0) / (REF * 8)) - 1, "R8 refresh under traffic",
          ref_cnt - r0, int'(($time - t0) / (REF * 8)));

    // idle: interval and pointer wrap
    idle_mode = 1'b1;
    repeat (REF * 70) @(negedge clk);
    idle_mode = 1'b0;
    check(wrap_seen && ref_cnt > 64, "R6 row pointer wrap", ref_cnt, 65);
    do_op(1'b0, 100, 1'b0, 1'b0);
    finish_run();
  end
endmodule